// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

A byte-oriented asynchronous serial port that sits behind a single-cycle 32-bit register strobe bus. Software pushes bytes into an 8-entry transmit queue and pops received bytes from an 8-entry receive queue. Each data register carries its own status in bit 31, so one read both moves data and reports whether the move happened.

The transmitter sends one start bit, then eight data bits least significant first, then one or two stop bits. Each bit lasts `div+1` system clocks. The receiver oversamples the line at the system clock rate. It rejects a start bit that has gone high again by mid-bit, and it takes every data bit at the centre of its bit time. Two level-sensitive pending flags compare each queue's occupancy against a programmable threshold. The interrupt output is the OR of the pending flags that are enabled.

The register word addresses are 0 transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt enable, 5 interrupt pending, 6 divisor. A read returns its data on `bus_rdata` one clock after the strobe.

Top module: `wm_uart`

## Requirements
- R1: The transmit control, receive control, interrupt enable and divisor registers read back their written fields. Control registers use bit 0 as enable, transmit control bit 1 as the stop field, and bits 16 and up as the threshold. Enable uses bit 0 for transmit and bit 1 for receive. The divisor sits in the low bits.
- R2: A read of transmit data returns 0x8000_0000 when the transmit queue is full and 0 otherwise. A write queues bits 7:0, and a write to a full queue is dropped.
- R3: A read of receive data pops the oldest byte into bits 7:0 with bit 31 clear. When the queue is empty it returns exactly 0x8000_0000 and pops nothing.
- R4: A transmitted frame is a low start bit, eight data bits least significant first, then a high stop level. Each bit lasts div+1 clocks, and queued bytes go out back to back with no idle gap.
- R5: Transmit control bit 1 selects the stop count: 0 gives one stop bit (a 10-bit frame) and 1 gives two (an 11-bit frame).
- R6: While transmit enable is clear, no frame starts, the line stays high and queued bytes stay queued.
- R7: While receive enable is set, a valid frame at the programmed divisor is stored. A low pulse shorter than half a bit is ignored. While receive enable is clear, nothing is stored.
- R8: A byte that completes while the receive queue is full is discarded, and the stored bytes are kept.
- R9: Pending bit 0 is set exactly while transmit occupancy is below the transmit threshold.
- R10: Pending bit 1 is set exactly while receive occupancy is above the receive threshold, so a threshold of 0 flags any stored byte.
- R11: `irq` is high exactly when some pending bit is set together with its enable bit.
- R12: After reset the line is high, `irq` is low, and all control, enable and divisor registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after the read strobe |
| irq | output | 1 | Combined enabled-watermark interrupt |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
The checker watches four things on every cycle:
- a write to a full transmit queue never grows it;
- an empty receive queue is never popped by a read;
- a full receive queue does not change except through a pop;
- the transmitter stays idle while disabled, and `irq` never rises with every enable clear.

Other behaviour appears only over whole frames, so only the bench scenarios show it. This covers bit order, stop-bit length measured as the spacing of back-to-back frames, centre sampling, glitch rejection, and where each watermark threshold falls. The bench also checks the exact byte sequence that comes back through a loopback and through an independently timed serial driver.

// File: rtl/wm_uart_pkg.sv
package wm_uart_pkg;
   localparam logic [2:0] REG_TXDATA = 3'd0;
   localparam logic [2:0] REG_RXDATA = 3'd1;
   localparam logic [2:0] REG_TXCTRL = 3'd2;
   localparam logic [2:0] REG_RXCTRL = 3'd3;
   localparam logic [2:0] REG_IE     = 3'd4;
   localparam logic [2:0] REG_IP     = 3'd5;
   localparam logic [2:0] REG_DIV    = 3'd6;
   localparam int         WM_LSB     = 16;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/wm_uart_fifo.sv
module wm_uart_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wnext, rnext;
   logic          do_push, do_pop;

   if (DEPTH < 2) begin : g_bad_depth
      $error("wm_uart_fifo: DEPTH must be at least 2");
   end

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wnext = wptr + 1'b1;
      assign rnext = rptr + 1'b1;
   end else begin : g_any
      assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/wm_uart_tx.sv
module wm_uart_tx #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             two_stop,
   input  logic [DIV_W-1:0] div,
   input  logic             q_empty,
   input  logic [7:0]       q_data,
   output logic             q_pop,
   output logic             busy,
   output logic             txd
);
   logic [10:0]      sh;
   logic [3:0]       bitn;
   logic [DIV_W-1:0] cnt;
   logic             bit_end, last, start;

   assign bit_end = busy && (cnt == div);
   assign last    = bit_end && (bitn == (two_stop ? 4'd10 : 4'd9));
   assign start   = en && !q_empty && (!busy || last);
   assign q_pop   = start;
   assign txd     = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         bitn <= '0;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (start) begin
         sh   <= {2'b11, q_data, 1'b0};
         bitn <= '0;
         cnt  <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (bit_end) begin
            cnt <= '0;
            if (last) begin
               busy <= 1'b0;
            end else begin
               sh   <= {1'b1, sh[10:1]};
               bitn <= bitn + 4'd1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wm_uart_rx.sv
module wm_uart_rx
   import wm_uart_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   input  logic             rxd,
   output logic             byte_valid,
   output logic [7:0]       byte_data
);
   logic             rxs;
   rx_state_e        st;
   logic [DIV_W-1:0] cnt;
   logic [2:0]       bitn;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rxs = rxd;
   end else if (SYNC_STAGES == 1) begin : g_sync1
      logic sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= 1'b1;
         else        sr <= rxd;
      end
      assign rxs = sr;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '1;
         else        sr <= {sr[SYNC_STAGES-2:0], rxd};
      end
      assign rxs = sr[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= RX_IDLE;
         cnt        <= '0;
         bitn       <= '0;
         byte_data  <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         case (st)
            RX_IDLE: begin
               cnt <= '0;
               if (en && !rxs) st <= RX_START;
            end
            RX_START: begin
               if (cnt == (div >> 1)) begin
                  cnt  <= '0;
                  bitn <= '0;
                  st   <= rxs ? RX_IDLE : RX_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_DATA: begin
               if (cnt == div) begin
                  cnt       <= '0;
                  byte_data <= {rxs, byte_data[7:1]};
                  bitn      <= bitn + 3'd1;
                  if (bitn == 3'd7) st <= RX_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (cnt == div) begin
                  byte_valid <= rxs;
                  st         <= RX_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wm_uart.sv
module wm_uart
   import wm_uart_pkg::*;
#(
   parameter int DEPTH       = 8,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [4:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   output logic        txd,
   input  logic        rxd
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
      $error("wm_uart: DIV_W must be 1..32");
   end
   if (CW > 32 - WM_LSB) begin : g_bad_wm
      $error("wm_uart: DEPTH too large for the threshold field");
   end

   logic [2:0]       sel;
   logic             tx_en, tx_two_stop, rx_en;
   logic [CW-1:0]    tx_wm, rx_wm, tx_count, rx_count;
   logic [1:0]       ie, ip;
   logic [DIV_W-1:0] div_q;
   logic             tx_push, tx_pop, tx_full, tx_empty, tx_busy;
   logic             rx_pop, rx_push, rx_full, rx_empty;
   logic [7:0]       tx_head, rx_head, rx_byte;
   logic [31:0]      rd_mux;
   logic             unused_bits;

   assign sel         = bus_addr[4:2];
   assign unused_bits = ^{bus_addr[1:0], bus_wdata, rx_full};
   assign tx_push     = bus_wr && (sel == REG_TXDATA);
   assign rx_pop      = bus_rd && (sel == REG_RXDATA) && !rx_empty;
   assign ip          = {(rx_count > rx_wm), (tx_count < tx_wm)};
   assign irq         = |(ie & ip);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en       <= 1'b0;
         tx_two_stop <= 1'b0;
         tx_wm       <= '0;
         rx_en       <= 1'b0;
         rx_wm       <= '0;
         ie          <= '0;
         div_q       <= '0;
      end else if (bus_wr) begin
         case (sel)
            REG_TXCTRL: begin
               tx_en       <= bus_wdata[0];
               tx_two_stop <= bus_wdata[1];
               tx_wm       <= bus_wdata[WM_LSB +: CW];
            end
            REG_RXCTRL: begin
               rx_en <= bus_wdata[0];
               rx_wm <= bus_wdata[WM_LSB +: CW];
            end
            REG_IE:  ie    <= bus_wdata[1:0];
            REG_DIV: div_q <= bus_wdata[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         REG_TXDATA: rd_mux[31] = tx_full;
         REG_RXDATA: begin
            rd_mux[31]  = rx_empty;
            rd_mux[7:0] = rx_empty ? 8'h00 : rx_head;
         end
         REG_TXCTRL: begin
            rd_mux[0]             = tx_en;
            rd_mux[1]             = tx_two_stop;
            rd_mux[WM_LSB +: CW]  = tx_wm;
         end
         REG_RXCTRL: begin
            rd_mux[0]             = rx_en;
            rd_mux[WM_LSB +: CW]  = rx_wm;
         end
         REG_IE:  rd_mux[1:0]       = ie;
         REG_IP:  rd_mux[1:0]       = ip;
         REG_DIV: rd_mux[DIV_W-1:0] = div_q;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   wm_uart_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
      .pop(tx_pop), .dout(tx_head), .count(tx_count),
      .full(tx_full), .empty(tx_empty));

   wm_uart_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
      .pop(rx_pop), .dout(rx_head), .count(rx_count),
      .full(rx_full), .empty(rx_empty));

   wm_uart_tx #(.DIV_W(DIV_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(tx_en), .two_stop(tx_two_stop),
      .div(div_q), .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop),
      .busy(tx_busy), .txd(txd));

   wm_uart_rx #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .div(div_q), .rxd(rxd),
      .byte_valid(rx_push), .byte_data(rx_byte));
endmodule

// File: rtl/wm_uart_chk.sv
module wm_uart_chk #(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [4:0]    bus_addr,
   input logic          irq,
   input logic [1:0]    ie,
   input logic [CW-1:0] tx_count,
   input logic [CW-1:0] rx_count,
   input logic          tx_pop,
   input logic          rx_push,
   input logic          rx_pop,
   input logic          tx_en,
   input logic          tx_busy
);
   AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[4:2] == 3'd0 && tx_count == CW'(DEPTH) && !tx_pop)
      |=> tx_count == CW'(DEPTH)); // R2

   AST_RX_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[4:2] == 3'd1 && rx_count == '0 && !rx_push)
      |=> rx_count == '0); // R3

   AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == CW'(DEPTH) && !rx_pop) |=> rx_count == CW'(DEPTH)); // R8

   AST_TX_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !tx_busy) |=> !tx_busy); // R6

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie != 2'b00)); // R11
endmodule

bind wm_uart wm_uart_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .irq(irq), .ie(ie), .tx_count(tx_count),
   .rx_count(rx_count), .tx_pop(tx_pop), .rx_push(rx_push),
   .rx_pop(rx_pop), .tx_en(tx_en), .tx_busy(tx_busy));

// File: tb/wm_uart_tb.sv
`timescale 1ns/1ps
module wm_uart_tb;
   localparam int DIV   = 3;
   localparam int BITC  = DIV + 1;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, txd;
   logic        loop = 1'b0, rxd_drv = 1'b1;
   wire         rxd = loop ? txd : rxd_drv;

   int checks = 0, fails = 0;
   int cyc = 0, last_fall = 0, last_gap = 0, nfalls = 0;
   logic prev_txd = 1'b1;

   always #2.5 clk = ~clk;

   wm_uart #(.DEPTH(DEPTH), .DIV_W(16), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .txd(txd), .rxd(rxd));

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (prev_txd && !txd) begin
         if (nfalls > 0) last_gap = cyc - last_fall;
         last_fall = cyc;
         nfalls = nfalls + 1;
      end
      prev_txd = txd;
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int word, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 5'(word * 4); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int word, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 5'(word * 4);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rxd_drv = 1'b0; repeat (BITC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd_drv = b[i]; repeat (BITC) @(negedge clk);
      end
      rxd_drv = 1'b1; repeat (2 * BITC) @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 37 + 5) & 255);
   endfunction

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int f0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R12 reset state
      check(txd == 1'b1, "R12 txd idle", 32'(txd), 32'h1);
      check(irq == 1'b0, "R12 irq low", 32'(irq), 32'h0);
      for (int r = 2; r <= 6; r++) begin
         rd(r, d);
         check(d == 32'h0, "R12 register zero", d, 32'h0);
      end
      // R3 empty read
      rd(1, d);
      check(d == 32'h8000_0000, "R3 empty rxdata", d, 32'h8000_0000);
      // R1 readback
      wr(2, 32'h0005_0002); rd(2, d);
      check(d == 32'h0005_0002, "R1 txctrl readback", d, 32'h0005_0002);
      wr(3, 32'h0003_0001); rd(3, d);
      check(d == 32'h0003_0001, "R1 rxctrl readback", d, 32'h0003_0001);
      wr(4, 32'h0000_0003); rd(4, d);
      check(d == 32'h3, "R1 ie readback", d, 32'h3);
      wr(6, 32'(DIV)); rd(6, d);
      check(d == 32'(DIV), "R1 div readback", d, 32'(DIV));
      wr(4, 32'h0); wr(3, 32'h0);
      // R6 disabled transmitter, threshold 4
      wr(2, 32'h0004_0000);
      f0 = nfalls;
      for (int k = 0; k < 3; k++) wr(0, 32'(pat(k)));
      idle(100);
      check(nfalls == f0 && txd, "R6 no frame while disabled", 32'(nfalls - f0), 32'h0);
      rd(5, d);
      check(d == 32'h1, "R9 3 below threshold 4", d, 32'h1);
      wr(2, 32'h0003_0000); rd(5, d);
      check(d == 32'h0, "R9 3 not below threshold 3", d, 32'h0);
      rd(0, d);
      check(d == 32'h0, "R2 not full", d, 32'h0);
      for (int k = 3; k < 9; k++) wr(0, 32'(pat(k)));
      rd(0, d);
      check(d == 32'h8000_0000, "R2 full flag", d, 32'h8000_0000);
      // loopback drain: R4, R7, R2 drop, R10
      loop = 1'b1;
      wr(3, 32'h0000_0001);
      wr(2, 32'h0003_0001);
      idle(12 * 10 * BITC);
      rd(5, d);
      check(d == 32'h3, "R9 R10 both pending after drain", d, 32'h3);
      for (int k = 0; k < 8; k++) begin
         rd(1, d);
         check(d == {24'h0, pat(k)}, "R4 R7 loopback byte", d, {24'h0, pat(k)});
      end
      rd(1, d);
      check(d == 32'h8000_0000, "R2 ninth write dropped", d, 32'h8000_0000);
      // R5 frame length, using all-ones bytes so only start bits fall
      wr(3, 32'h0); loop = 1'b0;
      wr(0, 32'hFF); wr(0, 32'hFF);
      idle(4 * 11 * BITC);
      check(last_gap == 10 * BITC, "R5 one stop bit frame", 32'(last_gap), 32'(10 * BITC));
      wr(2, 32'h0003_0003);
      wr(0, 32'hFF); wr(0, 32'hFF);
      idle(4 * 11 * BITC);
      check(last_gap == 11 * BITC, "R5 two stop bit frame", 32'(last_gap), 32'(11 * BITC));
      wr(2, 32'h0001_0001); rd(5, d);
      check(d == 32'h1, "R9 empty with threshold 1", d, 32'h1);
      // R10 receive threshold 2, R11 irq
      wr(2, 32'h0000_0001);
      wr(3, 32'h0002_0001);
      send(8'h96); send(8'h0F);
      rd(5, d);
      check(d == 32'h0, "R10 two not above two", d, 32'h0);
      send(8'hE1);
      rd(5, d);
      check(d == 32'h2, "R10 three above two", d, 32'h2);
      wr(4, 32'h1); idle(1);
      check(irq == 1'b0, "R11 masked pending", 32'(irq), 32'h0);
      wr(4, 32'h2); idle(1);
      check(irq == 1'b1, "R11 enabled pending", 32'(irq), 32'h1);
      rd(1, d); check(d == 32'h96, "R7 driver byte", d, 32'h96);
      rd(1, d); check(d == 32'h0F, "R7 driver byte", d, 32'h0F);
      idle(1);
      check(irq == 1'b0, "R11 irq follows level", 32'(irq), 32'h0);
      rd(1, d); check(d == 32'hE1, "R7 driver byte", d, 32'hE1);
      // R7 short glitch ignored
      @(negedge clk); rxd_drv = 1'b0; @(negedge clk); rxd_drv = 1'b1;
      idle(12 * BITC);
      rd(1, d);
      check(d == 32'h8000_0000, "R7 glitch ignored", d, 32'h8000_0000);
      // R7 receive disabled
      wr(3, 32'h0);
      send(8'h42);
      rd(1, d);
      check(d == 32'h8000_0000, "R7 disabled receiver", d, 32'h8000_0000);
      // R8 overflow
      wr(3, 32'h1);
      for (int k = 0; k < 9; k++) send(pat(k + 20));
      for (int k = 0; k < 8; k++) begin
         rd(1, d);
         check(d == {24'h0, pat(k + 20)}, "R8 kept bytes", d, {24'h0, pat(k + 20)});
      end
      rd(1, d);
      check(d == 32'h8000_0000, "R8 extra byte discarded", d, 32'h8000_0000);
      finish_run();
   end
endmodule